// File: doc/BRIEF.md
# Priority-Coded Sparse Neighbor Search

This block sits in front of a sparse convolution array. It is handed a flat occupancy bitmap of a voxel grid together with the linear index of a center voxel. From these it selects the local window around the center: 3x3x3 in volume mode, or 3x3 in the center's own plane in flat mode. It then lists every occupied neighbour in that window and emits one pair per cycle to two mapping FIFOs. Each pair holds the neighbour's feature-map index and the weight index of its position in the window.

The search never steps through empty window positions. A priority encoder finds the lowest pending bit of the captured window in a single cycle, and that bit is cleared as its pair is written. The cycle count of a run therefore follows the number of occupied neighbours and not the window size. For the non-submanifold dataflow the search is gated off: the run writes nothing and only signals completion.

Top module: `nbr_search`

## Requirements
- R1: While reset is asserted and after it is released, with no start, neither FIFO write enable is high and done is low.
- R2: In volume mode (mode_3d=1), window bit p = dz*9 + dy*3 + dx (dx, dy, dz in 0..2) is set iff grid voxel (cx+dx-1, cy+dy-1, cz+dz-1) lies inside the grid and is occupied. Linear index is x + GX*(y + GY*z), and occupancy bit i of occ belongs to linear index i.
- R3: In flat mode (mode_3d=0) only bits p = dy*3 + dx (0..8) are used, and they refer to voxel (cx+dx-1, cy+dy-1, cz).
- R4: Pairs are written in strictly ascending window-bit order. The first pair is written in the cycle after the accepting start, and writes follow in consecutive cycles while neither FIFO is full.
- R5: For each pair, wt_wr_idx equals the window bit p and fm_wr_idx equals the linear index of that neighbour. fm_wr_en and wt_wr_en are always equal.
- R6: No write happens in a cycle where fm_full or wt_full is high. The pending pair is held and written once space returns, so no pair is lost or repeated.
- R7: done is a one-cycle pulse in the cycle after the last write, or in the cycle after start when the window is empty. The block is idle in the next cycle.
- R8: With subm=0 at the accepting start, nothing is written and done pulses in the cycle after start.
- R9: start is ignored while a run is in progress, including in its done cycle. center, occ and mode are sampled only at the accepting start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| mode_3d | input | 1 | 1: 3x3x3 window, 0: 3x3 in-plane window |
| subm | input | 1 | 1: submanifold search, 0: search gated |
| center | input | IW | Linear index of the center voxel |
| occ | input | GX*GY*GZ | Occupancy bitmap, bit i for linear index i |
| fm_full | input | 1 | Feature-index FIFO full |
| wt_full | input | 1 | Weight-index FIFO full |
| fm_wr_en | output | 1 | Feature-index FIFO write |
| fm_wr_idx | output | IW | Neighbour linear index |
| wt_wr_en | output | 1 | Weight-index FIFO write |
| wt_wr_idx | output | PW | Window bit position |
| done | output | 1 | Run complete pulse |

## Verification
The runs use centers deep inside the grid and on corners and faces. Comparing the two separates correct clipping at the grid edge from plain index arithmetic. Random, full and empty occupancy in both modes exercises ordering, dense runs without gaps and the zero-length case. Random back-pressure on either FIFO shows whether a stalled pair is kept rather than dropped or repeated. Gated runs and a start held high across a run show that sampling happens only at the accepting edge.

// File: rtl/nbr_search_pkg.sv
package nbr_search_pkg;

  // offset of window bit p from the center, per axis
  function automatic void pos_delta(input int p, input bit m3, input int kw,
                                    output int ox, output int oy, output int oz);
    int h;
    h  = kw / 2;
    ox = (p % kw) - h;
    if (m3) begin
      oy = ((p / kw) % kw) - h;
      oz = (p / (kw * kw)) - h;
    end else begin
      oy = (p / kw) - h;
      oz = 0;
    end
  endfunction

  // window bit p exists in the selected mode
  function automatic bit pos_in_window(input int p, input bit m3, input int kw);
    return m3 || (p < kw * kw);
  endfunction

  // linear index of the neighbour, or -1 when it falls outside the grid
  function automatic int nbr_lin(input int c, input int gx, input int gy, input int gz,
                                 input int ox, input int oy, input int oz);
    int nx, ny, nz;
    nx = (c % gx) + ox;
    ny = ((c / gx) % gy) + oy;
    nz = (c / (gx * gy)) + oz;
    if (nx < 0 || ny < 0 || nz < 0 || nx >= gx || ny >= gy || nz >= gz) return -1;
    return nx + gx * (ny + gy * nz);
  endfunction

endpackage

// File: rtl/nbr_window.sv
module nbr_window #(
  parameter int GX  = 6,
  parameter int GY  = 6,
  parameter int GZ  = 4,
  parameter int KW  = 3,
  parameter int N   = GX * GY * GZ,
  parameter int IW  = $clog2(N),
  parameter int WIN = KW * KW * KW
) (
  input  logic [N-1:0]   occ,
  input  logic [IW-1:0]  center,
  input  logic           mode_3d,
  output logic [WIN-1:0] local_map
);
  import nbr_search_pkg::*;

  for (genvar p = 0; p < WIN; p++) begin : g_bit
    always_comb begin
      int ox, oy, oz, lin;
      pos_delta(p, mode_3d, KW, ox, oy, oz);
      lin = nbr_lin(int'(center), GX, GY, GZ, ox, oy, oz);
      if (pos_in_window(p, mode_3d, KW) && lin >= 0)
        local_map[p] = occ[lin[IW-1:0]];
      else
        local_map[p] = 1'b0;
    end
  end

endmodule

// File: rtl/lsb_pick.sv
module lsb_pick #(
  parameter int W  = 27,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [PW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (vec[i]) idx = PW'(i);
    any = |vec;
  end
endmodule

// File: rtl/nbr_search.sv
module nbr_search #(
  parameter int GX  = 6,
  parameter int GY  = 6,
  parameter int GZ  = 4,
  parameter int KW  = 3,
  localparam int N   = GX * GY * GZ,
  localparam int IW  = $clog2(N),
  localparam int WIN = KW * KW * KW,
  localparam int PW  = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_3d,
  input  logic          subm,
  input  logic [IW-1:0] center,
  input  logic [N-1:0]  occ,
  input  logic          fm_full,
  input  logic          wt_full,
  output logic          fm_wr_en,
  output logic [IW-1:0] fm_wr_idx,
  output logic          wt_wr_en,
  output logic [PW-1:0] wt_wr_idx,
  output logic          done
);
  import nbr_search_pkg::*;

  logic [WIN-1:0] win_now;
  logic [WIN-1:0] pend;
  logic [IW-1:0]  ctr_q;
  logic           m3_q;
  logic           busy;
  logic           have;
  logic [PW-1:0]  pick;

  // named events
  logic accept, advance, stalled, finish;

  nbr_window #(.GX(GX), .GY(GY), .GZ(GZ), .KW(KW), .N(N), .IW(IW), .WIN(WIN)) u_win (
    .occ(occ), .center(center), .mode_3d(mode_3d), .local_map(win_now)
  );

  lsb_pick #(.W(WIN), .PW(PW)) u_pick (.vec(pend), .any(have), .idx(pick));

  assign accept  = start && !busy;
  assign advance = busy && have && !fm_full && !wt_full;
  assign stalled = busy && have && (fm_full || wt_full);
  assign finish  = busy && !have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pend  <= '0;
      ctr_q <= '0;
      m3_q  <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      pend  <= subm ? win_now : '0;
      ctr_q <= center;
      m3_q  <= mode_3d;
    end else if (finish) begin
      busy  <= 1'b0;
    end else if (advance) begin
      pend  <= pend & ~(WIN'(1) << pick);
    end
  end

  always_comb begin
    int ox, oy, oz, lin;
    pos_delta(int'(pick), m3_q, KW, ox, oy, oz);
    lin       = nbr_lin(int'(ctr_q), GX, GY, GZ, ox, oy, oz);
    fm_wr_idx = lin[IW-1:0];
  end

  assign wt_wr_idx = pick;
  assign fm_wr_en  = advance;
  assign wt_wr_en  = advance;
  assign done      = finish;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fm_wr_en && !done);
  a_r4_one_bit_per_write: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> $countones(pend) == $countones($past(pend)) - 1);
  a_r5_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wt_wr_en |-> pend[wt_wr_idx]);
  a_r3_flat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_wr_en && !m3_q) |-> int'(wt_wr_idx) < KW * KW);
  a_r6_no_write_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_full || wt_full) |-> !fm_wr_en && !wt_wr_en);
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> $stable(pend) && busy);
  a_r7_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r8_gated_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !subm) |=> pend == '0);
  a_r9_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && have) |=> busy && $stable(ctr_q));

endmodule

// File: tb/sim_nbr_search.sv
module sim_nbr_search;
  localparam int GX = 6, GY = 6, GZ = 4;
  localparam int N  = GX * GY * GZ;
  localparam int IW = $clog2(N);
  localparam int PW = $clog2(27);

  logic clk = 0, rst_n = 0, start = 0, mode_3d = 1, subm = 1;
  logic [IW-1:0] center = '0;
  logic [N-1:0]  occ = '0;
  logic fm_full = 0, wt_full = 0;
  logic fm_wr_en, wt_wr_en, done;
  logic [IW-1:0] fm_wr_idx;
  logic [PW-1:0] wt_wr_idx;

  int checks = 0, fails = 0, cyc = 0;
  bit stall_en = 0;
  string cur_req = "R1";

  int q_fm[$];
  int q_wt[$];
  bit mbusy = 0;

  always #4 clk = ~clk;

  nbr_search #(.GX(GX), .GY(GY), .GZ(GZ), .KW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_3d(mode_3d), .subm(subm),
    .center(center), .occ(occ), .fm_full(fm_full), .wt_full(wt_full),
    .fm_wr_en(fm_wr_en), .fm_wr_idx(fm_wr_idx), .wt_wr_en(wt_wr_en),
    .wt_wr_idx(wt_wr_idx), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference: list the expected pairs in ascending window order
  task automatic build_list();
    int cx, cy, cz, c;
    c  = int'(center);
    cx = c % GX; cy = (c / GX) % GY; cz = c / (GX * GY);
    q_fm.delete(); q_wt.delete();
    for (int dz = 0; dz < 3; dz++)
      for (int dy = 0; dy < 3; dy++)
        for (int dx = 0; dx < 3; dx++) begin
          int x, y, z, lin;
          if (!mode_3d && dz > 0) continue;
          x = cx + dx - 1; y = cy + dy - 1;
          z = mode_3d ? cz + dz - 1 : cz;
          if (x < 0 || y < 0 || z < 0 || x >= GX || y >= GY || z >= GZ) continue;
          lin = x + GX * (y + GY * z);
          if (occ[lin]) begin
            q_fm.push_back(lin);
            q_wt.push_back(mode_3d ? dz * 9 + dy * 3 + dx : dy * 3 + dx);
          end
        end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mbusy = 0; q_fm.delete(); q_wt.delete();
    end else if (mbusy) begin
      if (q_fm.size() == 0) mbusy = 0;
      else if (!fm_full && !wt_full) begin
        void'(q_fm.pop_front()); void'(q_wt.pop_front());
      end
    end else if (start) begin
      mbusy = 1;
      if (subm) build_list();
      else begin q_fm.delete(); q_wt.delete(); end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ewr, edn;
      ewr = mbusy && q_fm.size() > 0 && !fm_full && !wt_full;
      edn = mbusy && q_fm.size() == 0;
      chk(fm_wr_en == ewr && wt_wr_en == ewr, (fm_full || wt_full) ? "R6" : cur_req,
          int'(fm_wr_en), int'(ewr));
      chk(done == edn, (cur_req == "R8") ? "R8" : "R7", int'(done), int'(edn));
      if (ewr && fm_wr_en) begin
        chk(int'(fm_wr_idx) == q_fm[0], (cur_req == "R3") ? "R3" : "R5",
            int'(fm_wr_idx), q_fm[0]);
        chk(int'(wt_wr_idx) == q_wt[0], "R4", int'(wt_wr_idx), q_wt[0]);
      end
    end
  end

  // random back-pressure on either FIFO
  always @(posedge clk) begin
    #2;
    if (stall_en) begin
      fm_full = ($urandom % 3) == 0;
      wt_full = ($urandom % 4) == 0;
    end else begin
      fm_full = 0; wt_full = 0;
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic rand_occ(input int pct);
    for (int i = 0; i < N; i++) occ[i] = ($urandom % 100) < pct;
  endtask

  task automatic wait_idle();
    int g = 0;
    do begin @(negedge clk); g++; end while (mbusy && g < 200);
  endtask

  task automatic run(input int c, input bit m3, input bit sm);
    @(posedge clk); #2;
    center = IW'(c); mode_3d = m3; subm = sm; start = 1;
    @(posedge clk); #2;
    start = 0;
    wait_idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!fm_wr_en && !wt_wr_en && !done, "R1", int'(fm_wr_en || done), 0);
    @(posedge clk); #2; rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!fm_wr_en && !done, "R1", int'(fm_wr_en || done), 0);

    // R2: interior center, random and full occupancy
    cur_req = "R2";
    rand_occ(50); run(1 + GX * (1 + GY * 1), 1, 1);
    occ = '1;     run(2 + GX * (3 + GY * 2), 1, 1);
    // R2: corner and face centers clip at the grid edge
    occ = '1;     run(0, 1, 1);
    rand_occ(60); run(N - 1, 1, 1);
    rand_occ(60); run(GX - 1 + GX * 2, 1, 1);

    // R3: flat mode
    cur_req = "R3";
    rand_occ(55); run(7 + GX * GY, 0, 1);
    occ = '1;     run(0, 0, 1);

    // R6: back-pressure
    cur_req = "R6";
    stall_en = 1;
    occ = '1;     run(1 + GX + GX * GY, 1, 1);
    rand_occ(50); run(14, 0, 1);
    stall_en = 0;

    // R7: empty window
    cur_req = "R7";
    occ = '0;     run(20, 1, 1);
    occ = '0;     run(20, 0, 1);

    // R8: gated search
    cur_req = "R8";
    occ = '1;     run(50, 1, 0);
    occ = '1;
    @(posedge clk); #2; center = 50; subm = 0; start = 1;
    @(posedge clk); #2; start = 0;
    @(negedge clk);
    chk(done && !fm_wr_en, "R8", int'(done), 1);
    wait_idle();

    // R9: start held high, inputs changed mid-run
    cur_req = "R9";
    occ = '1;
    @(posedge clk); #2; center = 50; mode_3d = 1; subm = 1; start = 1;
    repeat (4) @(posedge clk);
    #2; center = 0; rand_occ(40);
    repeat (40) @(posedge clk);
    #2; start = 0;
    wait_idle();

    // R4/R5: mixed random runs
    cur_req = "R4";
    for (int k = 0; k < 30; k++) begin
      stall_en = (k % 3) == 0;
      rand_occ(20 + (k * 7) % 70);
      run($urandom % N, k % 2, 1);
    end
    stall_en = 0;
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule